// File: doc/BRIEF.md
# Bidirectional Gated Row Scanner

This block is the digital model of the row-select side of a matrix display. It is a chain of row stages, and the chain is clocked from a slow line clock. On each rising edge of the line clock the chain samples the start input into its entry stage, and every other stage takes the value of its neighbour. The single marker therefore walks one row per line period. A direction input selects the walk. With direction high, the marker enters at the top row and moves down. With direction low, it enters at the bottom row and moves up.

The current chain contents reach the row outputs only while the enable input is high. Lowering enable blanks every row but does not stop the walk. Skipping lines, for example for a 50 Hz frame, is done by lowering enable and not pulsing the line clock. A low standby input holds the chain cleared and ignores line clock edges, so nothing is selected when operation resumes. A one-cycle frame-done pulse reports that the marker has left the last row in the active direction.

The line clock is sampled on the system clock `clk_i`, and a rising edge is detected from that sample. All state is reset asynchronously by `rst_ni`.

Top module: `row_scanner`

## Requirements
- R1: The parameter N_ROWS sets the row count and defaults to 225. Bit i of row_sel_o is row i, and bit 0 is the top row. After a single start pulse, exactly one row is selected in each line period.
- R2: A step is a rising line clock edge: line_clk_i is low in one clk_i sample and high in the next. With dir_i = 1, start_i is loaded into row 0 at a step, and a selected row i moves to row i+1 at each later step.
- R3: With dir_i = 0, start_i is loaded into row N_ROWS-1 at a step, and a selected row i moves to row i-1 at each later step. If dir_i changes mid-frame, the walk continues from the current row in the new direction.
- R4: While enable_i is low, row_sel_o is all zero and the scan position keeps advancing on steps. When enable_i goes high, the output shows the current position in the same cycle.
- R5: Holding line_clk_i high gives only one step. With the line clock paused, the scan position does not change, whatever enable_i does.
- R6: While standby_ni is low, the chain is cleared within one clk_i cycle and held at zero, steps are ignored, and frame_done_o stays low. After standby_ni returns high, no row is selected until a new start pulse is captured.
- R7: A start pulse captured while a marker is in flight loads the entry stage. The marker already in flight keeps moving, so both rows are selected.
- R8: frame_done_o is high for exactly one clk_i cycle. That cycle follows a step at which the last stage in the active direction held a 1: row N_ROWS-1 for dir_i = 1, row 0 for dir_i = 0.
- R9: While rst_ni is low, every stage is clear, row_sel_o is zero and frame_done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_clk_i | input | 1 | Line clock; a rising edge advances the scan |
| start_i | input | 1 | Start marker, sampled at a step |
| dir_i | input | 1 | 1: top to bottom, 0: bottom to top |
| enable_i | input | 1 | Output gate, active high |
| standby_ni | input | 1 | Power-save mode, active low; clears and freezes the chain |
| row_sel_o | output | N_ROWS | Row-select vector, bit 0 is the top row |
| frame_done_o | output | 1 | One-cycle pulse when the marker leaves the last row |

## Verification
The bench walks a full 225-row frame from top to bottom. A design with the wrong end stage or a missing stage would show the marker in the wrong row, or raise the frame-done pulse one step early or late.

It reverses direction in the middle of a frame. It also starts a marker from the bottom. This exposes a mux that treats direction as a reload, or one that enters at row 0 in both modes.

It blanks with enable low while steps continue, and expects the marker further along once enable rises. A design that gates the clock instead of the outputs would leave the marker behind.

Further tests:
- A line clock held high must not keep advancing the marker. A level-sensitive design would do so.
- A second start pulse in mid-frame must leave two markers. A design that clears the chain on start would lose the first one.
- Line edges in standby must not wake the chain.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef enum logic {
    SCAN_UP   = 1'b0,
    SCAN_DOWN = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/line_edge_detect.sv
module line_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_clk_i,
  output logic step_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= line_clk_i;
  end

  assign step_o = line_clk_i & ~line_q;
endmodule

// File: rtl/row_shift_chain.sv
module row_shift_chain
  import row_scan_pkg::*;
#(
  parameter int unsigned N_ROWS = 225
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              run_i,
  input  logic              start_i,
  input  scan_dir_e         dir_i,
  output logic [N_ROWS-1:0] chain_o,
  output logic              done_o
);
  localparam int unsigned LAST = N_ROWS - 1;

  logic [N_ROWS-1:0] chain_q;
  logic [N_ROWS-1:0] chain_d;
  logic              exit_bit;
  logic              done_q;

  for (genvar i = 0; i < N_ROWS; i++) begin : g_stage
    logic from_above;
    logic from_below;
    if (i == 0) begin : g_top
      assign from_above = start_i;
    end else begin : g_mid_a
      assign from_above = chain_q[i-1];
    end
    if (i == LAST) begin : g_bot
      assign from_below = start_i;
    end else begin : g_mid_b
      assign from_below = chain_q[i+1];
    end
    always_comb begin
      if (!run_i)      chain_d[i] = 1'b0;
      else if (step_i) chain_d[i] = (dir_i == SCAN_DOWN) ? from_above : from_below;
      else             chain_d[i] = chain_q[i];
    end
  end

  // the stage that falls off the end in the active direction
  assign exit_bit = (dir_i == SCAN_DOWN) ? chain_q[LAST] : chain_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      done_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      done_q  <= run_i & step_i & exit_bit;
    end
  end

  assign chain_o = chain_q;
  assign done_o  = done_q;
endmodule

// File: rtl/row_out_gate.sv
module row_out_gate #(
  parameter int unsigned N_ROWS = 225
) (
  input  logic              enable_i,
  input  logic [N_ROWS-1:0] chain_i,
  output logic [N_ROWS-1:0] row_sel_o
);
  assign row_sel_o = enable_i ? chain_i : '0;
endmodule

// File: rtl/row_scanner.sv
module row_scanner
  import row_scan_pkg::*;
#(
  parameter int unsigned N_ROWS = 225
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_clk_i,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic              enable_i,
  input  logic              standby_ni,
  output logic [N_ROWS-1:0] row_sel_o,
  output logic              frame_done_o
);
  logic              step;
  logic [N_ROWS-1:0] chain_q;

  line_edge_detect u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_clk_i (line_clk_i),
    .step_o     (step)
  );

  row_shift_chain #(.N_ROWS(N_ROWS)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .run_i   (standby_ni),
    .start_i (start_i),
    .dir_i   (scan_dir_e'(dir_i)),
    .chain_o (chain_q),
    .done_o  (frame_done_o)
  );

  row_out_gate #(.N_ROWS(N_ROWS)) u_gate (
    .enable_i  (enable_i),
    .chain_i   (chain_q),
    .row_sel_o (row_sel_o)
  );
endmodule

// File: rtl/row_scanner_chk.sv
module row_scanner_chk #(
  parameter int unsigned N_ROWS = 225
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              dir_i,
  input logic              enable_i,
  input logic              standby_ni,
  input logic              step,
  input logic [N_ROWS-1:0] chain_q,
  input logic [N_ROWS-1:0] row_sel_o,
  input logic              frame_done_o
);
  AST_BLANK_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> row_sel_o == '0); // R4

  AST_STANDBY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !standby_ni |=> chain_q == '0); // R6

  AST_STANDBY_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !standby_ni |=> !frame_done_o); // R6

  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_ni && !step) |=> $stable(chain_q)); // R5

  AST_DOWN_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_ni && step && dir_i) |=> chain_q[0] == $past(start_i)); // R2

  AST_UP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_ni && step && !dir_i) |=> chain_q[N_ROWS-1] == $past(start_i)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o); // R8

  AST_DONE_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(step)); // R8
endmodule

bind row_scanner row_scanner_chk #(.N_ROWS(N_ROWS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .dir_i        (dir_i),
  .enable_i     (enable_i),
  .standby_ni   (standby_ni),
  .step         (step),
  .chain_q      (chain_q),
  .row_sel_o    (row_sel_o),
  .frame_done_o (frame_done_o)
);

// File: tb/sim_row_scanner.sv
module sim_row_scanner;
  localparam int N = 225;
  localparam logic [9:0] NONE = 10'd1023;
  localparam int NVEC = 12;
  // {start, dir, en, stby, exp_done, exp_row}
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 10'd0},   // R2 load top
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd1},   // R2 move down
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, NONE},    // R4 blanked
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd3},   // R4 kept moving
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd2},   // R3 reversed
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd1},   // R3
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd0},   // R3
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, NONE},    // R8 out of top
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd224}, // R3 load bottom
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd223}, // R3
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, NONE},    // R6 standby clears
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, NONE}     // R6 stays clear
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_clk = 1'b0;
  logic start = 1'b0;
  logic dir = 1'b1;
  logic en = 1'b1;
  logic stby_n = 1'b1;
  logic [N-1:0] row_sel;
  logic frame_done;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic done_seen;

  always #10 clk = ~clk;

  row_scanner #(.N_ROWS(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_clk_i(line_clk), .start_i(start),
    .dir_i(dir), .enable_i(en), .standby_ni(stby_n),
    .row_sel_o(row_sel), .frame_done_o(frame_done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic line_step(input logic s, output logic d);
    @(negedge clk);
    line_clk = 1'b1;
    start = s;
    @(negedge clk);
    d = frame_done;
    line_clk = 1'b0;
    start = 1'b0;
  endtask

  task automatic chk_mask(input string req, input logic [N-1:0] exp);
    tests++;
    if (row_sel !== exp) begin
      fails++;
      $display("FAIL %s row_sel act=%h exp=%h", req, row_sel, exp);
    end
  endtask

  task automatic chk_row(input string req, input int idx);
    logic [N-1:0] e;
    e = '0;
    if (idx >= 0 && idx < N) e[idx] = 1'b1;
    chk_mask(req, e);
  endtask

  task automatic chk_done(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s frame_done act=%b exp=%b", req, act, exp);
    end
  endtask

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk_row("R9", -1);
    chk_done("R9", frame_done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_row("R9", -1);

    for (int v = 0; v < NVEC; v++) begin
      dir = VEC[v][13];
      en = VEC[v][12];
      stby_n = VEC[v][11];
      line_step(VEC[v][14], done_seen);
      chk_done("R8 table", done_seen, VEC[v][10]);
      chk_row("R2/R3/R4/R6 table", (VEC[v][9:0] == NONE) ? -1 : int'(VEC[v][9:0]));
    end

    // R1 full frame top to bottom, R8 at the exit
    dir = 1'b1; en = 1'b1; stby_n = 1'b1;
    line_step(1'b1, done_seen);
    chk_row("R1", 0);
    for (int k = 1; k < N; k++) begin
      line_step(1'b0, done_seen);
      chk_row("R1", k);
      chk_done("R8", done_seen, 1'b0);
    end
    line_step(1'b0, done_seen);
    chk_row("R1", -1);
    chk_done("R8", done_seen, 1'b1);
    @(negedge clk);
    chk_done("R8 single", frame_done, 1'b0);

    // R7 reload while in flight
    line_step(1'b1, done_seen);
    line_step(1'b0, done_seen);
    line_step(1'b1, done_seen);
    begin
      logic [N-1:0] m;
      m = '0; m[2] = 1'b1; m[0] = 1'b1;
      chk_mask("R7", m);
    end
    stby_n = 1'b0;
    @(negedge clk);
    stby_n = 1'b1;

    // R5 line clock held high advances once
    line_step(1'b1, done_seen);
    @(negedge clk);
    line_clk = 1'b1;
    repeat (5) @(negedge clk);
    chk_row("R5 held", 1);
    line_clk = 1'b0;
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk_row("R4 paused blank", -1);
    en = 1'b1;
    repeat (2) @(negedge clk);
    chk_row("R5 paused hold", 1);

    // R6 standby ignores edges
    stby_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      line_step(1'b1, done_seen);
      chk_done("R6", done_seen, 1'b0);
      chk_row("R6", -1);
    end
    stby_n = 1'b1;
    @(negedge clk);
    chk_row("R6 resume", -1);
    line_step(1'b0, done_seen);
    chk_row("R6 resume", -1);
    line_step(1'b1, done_seen);
    chk_row("R6 restart", 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule